// File: doc/BRIEF.md
# Panel Controller Host Register Port

This block is the host-facing side of a small TFT panel controller. A 16-bit parallel bus with a register-select line drives it. A write with the select line low loads a register index. Writes and reads with the select line high then go to whatever register that index names. Read data appears on `bus_rdata` in the cycle after the read strobe.

The block holds the configuration registers that the panel logic would consume. It also holds a horizontal and vertical RAM address pair and a rectangular window that confines those addresses. A data port at index 0x202 reads or writes one 16-bit pixel in an internal pixel store at the current address, then steps the address through the window in raster order. The panel is landscape, so horizontal addresses are 9 bits wide and vertical addresses are 8 bits wide.

The pixel store is indexed by the low `H_STORE_W` horizontal bits and the low `V_STORE_W` vertical bits. With the default values of 6 and 5, that is 64 x 32 pixels, and higher coordinates alias onto it. Setting the widths to 9 and 8 covers the full 396 x 224 panel.

Top module: `dc_host_port`

## Requirements
- R1: A bus write with `bus_rs` = 0 stores `bus_wdata` as the current index on the next clock edge. The index persists across any number of later data accesses (`bus_rs` = 1).
- R2: Reading index 0x000 returns 0x1524. Writes to index 0x000 do not change it.
- R3: The horizontal registers (0x200 counter, 0x210 window start, 0x211 window end) hold 9 bits. The vertical registers (0x201 counter, 0x212 start, 0x213 end) hold 8 bits. Bits above those widths read as 0.
- R4: After reset, 0x210 = 0, 0x211 = 395, 0x212 = 0, 0x213 = 223, and both counters are 0.
- R5: After reset, 0x001 = 0x0500, 0x002 = 0x0100, 0x003 = 0x00A0, 0x008 = 0x0808 and 0x00D = 0x8000. Each of these registers reads back the last 16-bit value written to it.
- R6: Index 0x010 resets to 0x36 and holds 6 bits. A write of a value from 0x10 to 0x3F is stored. A write of any other value leaves the register unchanged.
- R7: A data write at index 0x202 stores the pixel at the pixel-store location given by the current counters. A data read at 0x202 returns the pixel stored there, one cycle after the read strobe.
- R8: Each 0x202 access increments the horizontal counter. When the horizontal counter is at or beyond the window end, it instead reloads the window start and the vertical counter increments.
- R9: When the horizontal counter wraps and the vertical counter is at or beyond its window end, the vertical counter reloads the vertical window start.
- R10: Writing a window register (0x210 to 0x213) leaves both counters unchanged. Writing 0x200 or 0x201 loads that counter directly.
- R11: An index the block does not implement reads as 0. Writes to it change nothing visible.
- R12: A read at 0x202 advances the counters exactly as a write does.
- R13: With window start equal to end on both axes, successive 0x202 writes all land on the same pixel, and the counters stay on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rs | input | 1 | Register select: 0 = index cycle, 1 = data cycle |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe, one cycle per transfer |
| bus_wdata | input | 16 | Write data or index |
| bus_rdata | output | 16 | Read data, valid in the cycle after `bus_rd` |

## Verification
The bench targets the window stepping at its edges: the horizontal wrap into the next line and the vertical wrap back to the top. A design with an off-by-one comparison would write a pixel outside the window, and one that ignored the vertical end would leave the window entirely. It checks that reads at the data port advance the counters, because a design that did not would return the same pixel repeatedly. It also checks that window writes leave the counters in place, which a design that reloaded on window writes would fail. Further checks cover rejection of out-of-range frame-rate values, masking of the narrow coordinate fields, the read-only device code and the one-pixel window, where a wrong design would smear successive colours across neighbouring pixels.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int DW = 16;

    localparam logic [DW-1:0] DEVICE_CODE = 16'h1524;

    localparam logic [DW-1:0] IX_DEVCODE = 16'h0000;
    localparam logic [DW-1:0] IX_FRAME   = 16'h0010;
    localparam logic [DW-1:0] IX_HADDR   = 16'h0200;
    localparam logic [DW-1:0] IX_VADDR   = 16'h0201;
    localparam logic [DW-1:0] IX_GRAM    = 16'h0202;
    localparam logic [DW-1:0] IX_WIN_HS  = 16'h0210;
    localparam logic [DW-1:0] IX_WIN_HE  = 16'h0211;
    localparam logic [DW-1:0] IX_WIN_VS  = 16'h0212;
    localparam logic [DW-1:0] IX_WIN_VE  = 16'h0213;

    localparam int FRAME_W = 6;
    localparam logic [FRAME_W-1:0] FRAME_RST = 6'h36;
    localparam logic [DW-1:0] FRAME_LO = 16'h0010;
    localparam logic [DW-1:0] FRAME_HI = 16'h003F;

    // plain stored registers: full-width storage, no side effects
    localparam int N_PLAIN = 5;

    function automatic logic [DW-1:0] plain_index(input int slot);
        case (slot)
            0:       return 16'h0001;
            1:       return 16'h0002;
            2:       return 16'h0003;
            3:       return 16'h0008;
            default: return 16'h000D;
        endcase
    endfunction

    function automatic logic [DW-1:0] plain_reset(input int slot);
        case (slot)
            0:       return 16'h0500;
            1:       return 16'h0100;
            2:       return 16'h00A0;
            3:       return 16'h0808;
            default: return 16'h8000;
        endcase
    endfunction

    function automatic logic frame_ok(input logic [DW-1:0] value);
        return (value >= FRAME_LO) && (value <= FRAME_HI);
    endfunction

    typedef struct packed {
        logic          wr;     // data write (select high)
        logic          rd;     // data read (select high)
        logic [DW-1:0] idx;    // current register index
        logic [DW-1:0] wdata;
    } dc_access_t;

endpackage

// File: rtl/dc_cfg_regs.sv
module dc_cfg_regs
    import dc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DW-1:0]       idx,
    input  logic [DW-1:0]       wdata,
    output logic                hit,
    output logic [DW-1:0]       rvalue,
    output logic [FRAME_W-1:0]  frame_val
);

    logic [N_PLAIN-1:0][DW-1:0] store_q;
    logic [N_PLAIN-1:0]         match;
    logic [FRAME_W-1:0]         frame_q;
    logic                       frame_sel;

    for (genvar g = 0; g < N_PLAIN; g++) begin : g_match
        localparam logic [DW-1:0] SLOT_IX = plain_index(g);
        assign match[g] = (idx == SLOT_IX);
    end

    assign frame_sel = (idx == IX_FRAME);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_PLAIN; i++) store_q[i] <= plain_reset(i);
        end else if (wr_en) begin
            for (int i = 0; i < N_PLAIN; i++)
                if (match[i]) store_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            frame_q <= FRAME_RST;
        else if (wr_en && frame_sel && frame_ok(wdata))
            frame_q <= wdata[FRAME_W-1:0];
    end

    always_comb begin
        hit    = 1'b0;
        rvalue = '0;
        if (idx == IX_DEVCODE) begin
            hit    = 1'b1;
            rvalue = DEVICE_CODE;
        end else if (frame_sel) begin
            hit    = 1'b1;
            rvalue = DW'(frame_q);
        end else begin
            for (int i = 0; i < N_PLAIN; i++) begin
                if (match[i]) begin
                    hit    = 1'b1;
                    rvalue = store_q[i];
                end
            end
        end
    end

    assign frame_val = frame_q;

endmodule

// File: rtl/dc_addr_ctrl.sv
module dc_addr_ctrl
    import dc_pkg::*;
#(
    parameter int H_ADDR_W = 9,
    parameter int V_ADDR_W = 8,
    parameter int H_PIXELS = 396,
    parameter int V_PIXELS = 224
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DW-1:0]       idx,
    input  logic [H_ADDR_W-1:0] h_wdata,
    input  logic [V_ADDR_W-1:0] v_wdata,
    input  logic                step,
    output logic                hit,
    output logic [DW-1:0]       rvalue,
    output logic [H_ADDR_W-1:0] h_addr,
    output logic [V_ADDR_W-1:0] v_addr,
    output logic [H_ADDR_W-1:0] win_hs,
    output logic [H_ADDR_W-1:0] win_he,
    output logic [V_ADDR_W-1:0] win_vs,
    output logic [V_ADDR_W-1:0] win_ve
);

    localparam logic [H_ADDR_W-1:0] H_END_RST = H_ADDR_W'(H_PIXELS - 1);
    localparam logic [V_ADDR_W-1:0] V_END_RST = V_ADDR_W'(V_PIXELS - 1);

    logic [H_ADDR_W-1:0] h_q, hs_q, he_q;
    logic [V_ADDR_W-1:0] v_q, vs_q, ve_q;
    logic                h_wrap, v_wrap;

    assign h_wrap = (h_q >= he_q);
    assign v_wrap = (v_q >= ve_q);

    // window registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= '0;
            he_q <= H_END_RST;
            vs_q <= '0;
            ve_q <= V_END_RST;
        end else if (wr_en) begin
            if (idx == IX_WIN_HS) hs_q <= h_wdata;
            if (idx == IX_WIN_HE) he_q <= h_wdata;
            if (idx == IX_WIN_VS) vs_q <= v_wdata;
            if (idx == IX_WIN_VE) ve_q <= v_wdata;
        end
    end

    // address counters: direct load or raster step inside the window
    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
            v_q <= '0;
        end else if (wr_en && idx == IX_HADDR) begin
            h_q <= h_wdata;
        end else if (wr_en && idx == IX_VADDR) begin
            v_q <= v_wdata;
        end else if (step) begin
            if (h_wrap) begin
                h_q <= hs_q;
                v_q <= v_wrap ? vs_q : v_q + 1'b1;
            end else begin
                h_q <= h_q + 1'b1;
            end
        end
    end

    always_comb begin
        hit    = 1'b1;
        rvalue = '0;
        case (idx)
            IX_HADDR:  rvalue = DW'(h_q);
            IX_VADDR:  rvalue = DW'(v_q);
            IX_WIN_HS: rvalue = DW'(hs_q);
            IX_WIN_HE: rvalue = DW'(he_q);
            IX_WIN_VS: rvalue = DW'(vs_q);
            IX_WIN_VE: rvalue = DW'(ve_q);
            default:   hit = 1'b0;
        endcase
    end

    assign h_addr = h_q;
    assign v_addr = v_q;
    assign win_hs = hs_q;
    assign win_he = he_q;
    assign win_vs = vs_q;
    assign win_ve = ve_q;

endmodule

// File: rtl/dc_gram.sv
module dc_gram
    import dc_pkg::*;
#(
    parameter int H_STORE_W = 6,
    parameter int V_STORE_W = 5
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic                 re,
    input  logic [H_STORE_W-1:0] h,
    input  logic [V_STORE_W-1:0] v,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        q
);

    localparam int AW    = H_STORE_W + V_STORE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] addr;

    assign addr = {v, h};

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) q <= mem[addr];
    end

endmodule

// File: rtl/dc_host_port.sv
module dc_host_port
    import dc_pkg::*;
#(
    parameter int H_ADDR_W  = 9,
    parameter int V_ADDR_W  = 8,
    parameter int H_PIXELS  = 396,
    parameter int V_PIXELS  = 224,
    parameter int H_STORE_W = 6,
    parameter int V_STORE_W = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rs,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);

    dc_access_t          acc;
    logic [DW-1:0]       idx_q;
    logic                gram_sel, step;
    logic                cfg_hit, addr_hit;
    logic [DW-1:0]       cfg_val, addr_val, rmux, rdata_q, gram_q;
    logic                from_gram_q;
    logic [FRAME_W-1:0]  frame_val;
    logic [H_ADDR_W-1:0] h_addr, win_hs, win_he;
    logic [V_ADDR_W-1:0] v_addr, win_vs, win_ve;

    // index cycle: select low
    always_ff @(posedge clk) begin
        if (rst)                  idx_q <= IX_DEVCODE;
        else if (bus_wr && !bus_rs) idx_q <= bus_wdata;
    end

    assign acc.wr    = bus_wr & bus_rs;
    assign acc.rd    = bus_rd & bus_rs;
    assign acc.idx   = idx_q;
    assign acc.wdata = bus_wdata;

    assign gram_sel = (acc.idx == IX_GRAM);
    assign step     = gram_sel & (acc.wr | acc.rd);

    dc_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (acc.wr),
        .idx       (acc.idx),
        .wdata     (acc.wdata),
        .hit       (cfg_hit),
        .rvalue    (cfg_val),
        .frame_val (frame_val)
    );

    dc_addr_ctrl #(
        .H_ADDR_W (H_ADDR_W),
        .V_ADDR_W (V_ADDR_W),
        .H_PIXELS (H_PIXELS),
        .V_PIXELS (V_PIXELS)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc.wr),
        .idx     (acc.idx),
        .h_wdata (acc.wdata[H_ADDR_W-1:0]),
        .v_wdata (acc.wdata[V_ADDR_W-1:0]),
        .step    (step),
        .hit     (addr_hit),
        .rvalue  (addr_val),
        .h_addr  (h_addr),
        .v_addr  (v_addr),
        .win_hs  (win_hs),
        .win_he  (win_he),
        .win_vs  (win_vs),
        .win_ve  (win_ve)
    );

    dc_gram #(
        .H_STORE_W (H_STORE_W),
        .V_STORE_W (V_STORE_W)
    ) u_gram (
        .clk   (clk),
        .we    (gram_sel & acc.wr),
        .re    (gram_sel & acc.rd),
        .h     (h_addr[H_STORE_W-1:0]),
        .v     (v_addr[V_STORE_W-1:0]),
        .wdata (acc.wdata),
        .q     (gram_q)
    );

    always_comb begin
        if (cfg_hit)       rmux = cfg_val;
        else if (addr_hit) rmux = addr_val;
        else               rmux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q     <= '0;
            from_gram_q <= 1'b0;
        end else if (acc.rd) begin
            rdata_q     <= rmux;
            from_gram_q <= gram_sel;
        end
    end

    assign bus_rdata = from_gram_q ? gram_q : rdata_q;

endmodule

// File: rtl/dc_host_port_chk.sv
module dc_host_port_chk #(
    parameter int H_ADDR_W = 9,
    parameter int V_ADDR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_rs,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [15:0]         bus_wdata,
    input logic [15:0]         bus_rdata,
    input logic [15:0]         idx_q,
    input logic [5:0]          frame_val,
    input logic [H_ADDR_W-1:0] h_addr,
    input logic [V_ADDR_W-1:0] v_addr,
    input logic [H_ADDR_W-1:0] win_hs,
    input logic [H_ADDR_W-1:0] win_he,
    input logic [V_ADDR_W-1:0] win_vs,
    input logic [V_ADDR_W-1:0] win_ve
);

    logic data_wr, data_rd, px_acc, win_wr;
    assign data_wr = bus_wr && bus_rs;
    assign data_rd = bus_rd && bus_rs;
    assign px_acc  = (data_wr || data_rd) && idx_q == 16'h0202;
    assign win_wr  = data_wr && idx_q[15:2] == 14'h0084;

    p_index_load_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rs) |=> idx_q == $past(bus_wdata));

    p_devcode_r2: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_q == 16'h0000) |=> bus_rdata == 16'h1524);

    p_vwidth_r3: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_q == 16'h0201) |=> bus_rdata[15:V_ADDR_W] == '0);

    p_frame_range_r6: assert property (@(posedge clk) disable iff (rst)
        frame_val >= 6'h10);

    p_hstep_r8: assert property (@(posedge clk) disable iff (rst)
        (px_acc && h_addr < win_he) |=> h_addr == H_ADDR_W'($past(h_addr) + 1'b1));

    p_hwrap_r8: assert property (@(posedge clk) disable iff (rst)
        (px_acc && h_addr >= win_he) |=> h_addr == $past(win_hs));

    p_vwrap_r9: assert property (@(posedge clk) disable iff (rst)
        (px_acc && h_addr >= win_he && v_addr >= win_ve) |=> v_addr == $past(win_vs));

    p_win_hold_r10: assert property (@(posedge clk) disable iff (rst)
        win_wr |=> $stable(h_addr) && $stable(v_addr));

    p_read_step_r12: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_q == 16'h0202 && h_addr < win_he)
            |=> h_addr == H_ADDR_W'($past(h_addr) + 1'b1));

endmodule

bind dc_host_port dc_host_port_chk #(
    .H_ADDR_W (H_ADDR_W),
    .V_ADDR_W (V_ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rs    (bus_rs),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .idx_q     (idx_q),
    .frame_val (frame_val),
    .h_addr    (h_addr),
    .v_addr    (v_addr),
    .win_hs    (win_hs),
    .win_he    (win_he),
    .win_vs    (win_vs),
    .win_ve    (win_ve)
);

// File: tb/dc_host_port_test.sv
module dc_host_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rs = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    always #10 clk = ~clk;   // 50 MHz

    dc_host_port uut (
        .clk       (clk),
        .rst       (rst),
        .bus_rs    (bus_rs),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    checks = 0;
    int    errors = 0;
    logic  rd_q = 1'b0;
    bit    done = 1'b0;

    // monitor: a read strobe seen at an edge is answered by the next negedge
    always @(posedge clk) rd_q <= bus_rd & bus_rs;

    always @(negedge clk) begin
        if (rd_q) begin
            item_t it;
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation, actual %h expected none", bus_rdata);
            end else begin
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic sel(input logic [15:0] ix);
        @(negedge clk);
        bus_rs = 1'b0; bus_wr = 1'b1; bus_wdata = ix;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wdat(input logic [15:0] val);
        @(negedge clk);
        bus_rs = 1'b1; bus_wr = 1'b1; bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic put(input logic [15:0] ix, input logic [15:0] val);
        sel(ix);
        wdat(val);
    endtask

    task automatic rdat(input logic [15:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        @(negedge clk);
        sbq.push_back(it);
        bus_rs = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [15:0] ix, input logic [15:0] exp, input string tag);
        sel(ix);
        rdat(exp, tag);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 device code, read-only
        chk(16'h0000, 16'h1524, "R2 device code");
        wdat(16'hFFFF);
        rdat(16'h1524, "R2 device code after write");

        // R5 reset values and readback
        chk(16'h0001, 16'h0500, "R5 reset 0x001");
        chk(16'h0002, 16'h0100, "R5 reset 0x002");
        chk(16'h0003, 16'h00A0, "R5 reset 0x003");
        chk(16'h0008, 16'h0808, "R5 reset 0x008");
        chk(16'h000D, 16'h8000, "R5 reset 0x00D");
        put(16'h0003, 16'h1234);
        rdat(16'h1234, "R5 readback 0x003");
        // R1 index persists across data accesses
        rdat(16'h1234, "R1 index held");

        // R6 frame register range
        chk(16'h0010, 16'h0036, "R6 reset");
        wdat(16'h000F);
        rdat(16'h0036, "R6 below range ignored");
        wdat(16'h0040);
        rdat(16'h0036, "R6 above range ignored");
        wdat(16'h003F);
        rdat(16'h003F, "R6 upper bound stored");
        wdat(16'h0010);
        rdat(16'h0010, "R6 lower bound stored");

        // R4 window and counter reset
        chk(16'h0210, 16'd0,   "R4 h start");
        chk(16'h0211, 16'd395, "R4 h end");
        chk(16'h0212, 16'd0,   "R4 v start");
        chk(16'h0213, 16'd223, "R4 v end");
        chk(16'h0200, 16'd0,   "R4 h counter");
        chk(16'h0201, 16'd0,   "R4 v counter");

        // R3 field widths
        put(16'h0200, 16'hFFFF);
        rdat(16'h01FF, "R3 h counter width");
        put(16'h0201, 16'hFFFF);
        rdat(16'h00FF, "R3 v counter width");
        put(16'h0211, 16'hFFFF);
        rdat(16'h01FF, "R3 h end width");
        put(16'h0213, 16'hFFFF);
        rdat(16'h00FF, "R3 v end width");

        // R11 unimplemented indices
        chk(16'h0123, 16'h0000, "R11 read zero");
        wdat(16'hABCD);
        rdat(16'h0000, "R11 write discarded");
        put(16'h0005, 16'h5555);
        rdat(16'h0000, "R11 write discarded 0x005");

        // R8 R9 window raster stepping
        put(16'h0210, 16'd2);
        put(16'h0211, 16'd4);
        put(16'h0212, 16'd1);
        put(16'h0213, 16'd2);
        put(16'h0200, 16'd2);
        put(16'h0201, 16'd1);
        sel(16'h0202);
        for (int k = 0; k < 3; k++) wdat(16'hA000 + 16'(k));
        chk(16'h0200, 16'd2, "R8 h wrap to start");
        chk(16'h0201, 16'd2, "R8 v increment");
        sel(16'h0202);
        for (int k = 3; k < 6; k++) wdat(16'hA000 + 16'(k));
        chk(16'h0200, 16'd2, "R9 h after frame");
        chk(16'h0201, 16'd1, "R9 v wrap to start");

        // R7 R12 pixel readback with advancing reads
        sel(16'h0202);
        rdat(16'hA000, "R7 pixel (2,1)");
        chk(16'h0200, 16'd3, "R12 read advances h");
        sel(16'h0202);
        for (int k = 1; k < 6; k++) rdat(16'hA000 + 16'(k), "R7 R12 pixel stream");
        chk(16'h0200, 16'd2, "R12 h after read frame");
        chk(16'h0201, 16'd1, "R12 v after read frame");

        // R10 window writes do not move counters
        put(16'h0210, 16'd5);
        put(16'h0213, 16'd9);
        chk(16'h0200, 16'd2, "R10 h held");
        chk(16'h0201, 16'd1, "R10 v held");
        put(16'h0200, 16'd7);
        rdat(16'd7, "R10 direct load h");

        // R13 single-pixel window
        put(16'h0210, 16'd10);
        put(16'h0211, 16'd10);
        put(16'h0212, 16'd3);
        put(16'h0213, 16'd3);
        put(16'h0200, 16'd10);
        put(16'h0201, 16'd3);
        sel(16'h0202);
        wdat(16'h1111);
        wdat(16'h2222);
        rdat(16'h2222, "R13 same pixel overwritten");
        chk(16'h0200, 16'd10, "R13 h pinned");
        chk(16'h0201, 16'd3,  "R13 v pinned");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        finish_run();
    end

endmodule